// File: doc/BRIEF.md
# Task Memory Relocation and Opcode Trap Unit

This unit sits inline between a processor and a shared memory space. On every memory access it adds the current task's base offset to the logical address to form the physical address, and it compares that physical address against the task's upper limit. An access that lands above the limit, or whose addition carries out past the top of physical memory, never reaches memory. The unit raises a fault one cycle later and latches the offending logical address. Several tasks can therefore occupy one memory without writing over each other.

The unit also inspects every fetched instruction word. Opcodes that fall in a programmable reserved range raise a trap. The trap is classed as serviced locally, for example an I/O request, when the opcode also lies in a programmable sub-range. Any other trapped opcode is passed to the executive. Base, limit and the opcode bounds are loaded through a register write port that only works while the supervisor input is high.

Top module: `task_reloc_trap`

## Requirements
- R1: After reset the unit shows mem_req_o=0, fault_o=0, trap_o=0, trap_local_o=0 and fault_addr_o=0. Base resets to 0 and limit resets to all ones, so a logical address passes through unchanged. Both trap ranges reset empty (low bound 1, high bound 0).
- R2: In the same cycle as the access, mem_addr_o equals base plus the zero-extended cpu_addr_i. mem_we_o follows cpu_we_i.
- R3: If the physical address is greater than the limit, mem_req_o stays low in that cycle. fault_o is then high for exactly one cycle, in the cycle after the access. A physical address equal to the limit is allowed.
- R4: On a violation, fault_addr_o captures the logical address of that access. It holds this value until the next violation.
- R5: A base-plus-address sum that carries past 2^PADDR_W is a violation, whatever the limit is.
- R6: The configuration is written on a clock edge where cfg_we_i and sup_i are both high. The register is chosen by cfg_sel_i: 0 base, 1 limit, 2 trap low, 3 trap high, 4 local low, 5 local high. Opcode bounds take the low OP_W bits of cfg_wdata_i. A write with sup_i low has no effect.
- R7: The opcode is the top OP_W bits of ins_word_i. When ins_valid_i is high and trap low ≤ opcode ≤ trap high (bounds inclusive), trap_o is high in the next cycle.
- R8: A trapped opcode that also satisfies local low ≤ opcode ≤ local high sets trap_local_o together with trap_o. Any other trapped opcode leaves trap_local_o low, which marks the executive class.
- R9: An opcode outside the trap range, or any word presented with ins_valid_i low, produces no trap in the next cycle.
- R10: A configuration write applies to the first access in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_i | input | 1 | Supervisor mode; enables configuration writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | PADDR_W | Configuration write data |
| cpu_req_i | input | 1 | Processor memory access request |
| cpu_we_i | input | 1 | Processor write flag |
| cpu_addr_i | input | LADDR_W | Logical address |
| mem_req_o | output | 1 | Memory strobe, gated by the protection check |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | PADDR_W | Relocated physical address |
| fault_o | output | 1 | Limit violation, one cycle after the access |
| fault_addr_o | output | LADDR_W | Logical address of the latest violation |
| ins_valid_i | input | 1 | Fetched instruction word valid |
| ins_word_i | input | DATA_W | Fetched instruction word |
| trap_o | output | 1 | Reserved opcode trapped |
| trap_local_o | output | 1 | Trap belongs to the locally serviced class |

## Verification
The relocated address, mem_we_o and the gated strobe are combinational. The bench checks them a moment after it drives the access, while that access is still held. fault_o, fault_addr_o, trap_o and trap_local_o come from registers loaded on the edge that ends the stimulus cycle, so the bench samples them at the following falling edge. It samples once more a cycle later to confirm the fault pulse has ended and the captured address is held. Configuration writes are followed by an access in the very next cycle, which shows that the new value applies to that access.

// File: rtl/task_reloc_trap.sv
module task_reloc_trap #(
  parameter int LADDR_W = 16,
  parameter int PADDR_W = 18,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sup_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_sel_i,
  input  logic [PADDR_W-1:0] cfg_wdata_i,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [LADDR_W-1:0] cpu_addr_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PADDR_W-1:0] mem_addr_o,
  output logic               fault_o,
  output logic [LADDR_W-1:0] fault_addr_o,
  input  logic               ins_valid_i,
  input  logic [DATA_W-1:0]  ins_word_i,
  output logic               trap_o,
  output logic               trap_local_o
);
  localparam int SUM_W = PADDR_W + 1;

  logic [PADDR_W-1:0] base_q, limit_q;
  logic [OP_W-1:0]    trap_lo_q, trap_hi_q, loc_lo_q, loc_hi_q;
  logic [SUM_W-1:0]   sum;
  logic               viol, cfg_ok;
  logic [OP_W-1:0]    opcode;
  logic               in_trap, in_loc;

  assign sum  = {1'b0, base_q} + {{(SUM_W-LADDR_W){1'b0}}, cpu_addr_i};
  assign viol = sum[PADDR_W] | (sum[PADDR_W-1:0] > limit_q);

  assign mem_addr_o = sum[PADDR_W-1:0];
  assign mem_we_o   = cpu_we_i;
  assign mem_req_o  = cpu_req_i & ~viol;

  assign opcode  = ins_word_i[DATA_W-1 -: OP_W];
  assign in_trap = (opcode >= trap_lo_q) && (opcode <= trap_hi_q);
  assign in_loc  = (opcode >= loc_lo_q) && (opcode <= loc_hi_q);
  assign cfg_ok  = cfg_we_i & sup_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      limit_q   <= '1;
      trap_lo_q <= OP_W'(1);
      trap_hi_q <= '0;
      loc_lo_q  <= OP_W'(1);
      loc_hi_q  <= '0;
    end else if (cfg_ok) begin
      case (cfg_sel_i)
        3'd0: base_q    <= cfg_wdata_i;
        3'd1: limit_q   <= cfg_wdata_i;
        3'd2: trap_lo_q <= cfg_wdata_i[OP_W-1:0];
        3'd3: trap_hi_q <= cfg_wdata_i[OP_W-1:0];
        3'd4: loc_lo_q  <= cfg_wdata_i[OP_W-1:0];
        3'd5: loc_hi_q  <= cfg_wdata_i[OP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
      trap_o       <= 1'b0;
      trap_local_o <= 1'b0;
    end else begin
      fault_o      <= cpu_req_i & viol;
      if (cpu_req_i & viol) fault_addr_o <= cpu_addr_i;
      trap_o       <= ins_valid_i & in_trap;
      trap_local_o <= ins_valid_i & in_trap & in_loc;
    end
  end

  AST_BLOCKED_THEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && !mem_req_o) |=> fault_o); // R3
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_addr_o == $past(cpu_addr_i)); // R4
  AST_LOCAL_IS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_local_o |-> trap_o); // R8
  AST_NO_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid_i |=> !trap_o); // R9
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sup_i) |-> ($stable(base_q) && $stable(limit_q))); // R6
endmodule

// File: tb/task_reloc_trap_tb_top.sv
module task_reloc_trap_tb_top;
  localparam int LW = 16, PW = 18, DW = 16, OW = 6;

  logic clk = 0, rst_n = 0, sup = 0, cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [PW-1:0] cfg_wdata = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [LW-1:0] cpu_addr = 0;
  logic mem_req, mem_we, fault, trap, trap_local;
  logic [PW-1:0] mem_addr;
  logic [LW-1:0] fault_addr;
  logic ins_valid = 0;
  logic [DW-1:0] ins_word = 0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  task_reloc_trap #(.LADDR_W(LW), .PADDR_W(PW), .DATA_W(DW), .OP_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_i(sup), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .fault_o(fault),
    .fault_addr_o(fault_addr), .ins_valid_i(ins_valid), .ins_word_i(ins_word),
    .trap_o(trap), .trap_local_o(trap_local));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [PW-1:0] d, input logic s);
    @(negedge clk);
    sup = s; cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    sup = 0; cfg_we = 0;
  endtask

  task automatic access(input logic [LW-1:0] a, input logic w, input logic [PW-1:0] exp_pa,
                        input logic exp_ok, input string req);
    cpu_req = 1; cpu_we = w; cpu_addr = a;
    #1;
    chk(req, {31'b0, mem_req}, {31'b0, exp_ok});
    if (exp_ok) begin
      chk(req, {14'b0, mem_addr}, {14'b0, exp_pa});
      chk(req, {31'b0, mem_we}, {31'b0, w});
    end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    chk(req, {31'b0, fault}, {31'b0, !exp_ok});
    if (!exp_ok) chk("R4", {16'b0, fault_addr}, {16'b0, a});
  endtask

  task automatic fetch(input logic [OW-1:0] op, input logic v, input logic exp_t,
                       input logic exp_l, input string req);
    @(negedge clk);
    ins_valid = v; ins_word = {op, 10'h155};
    @(negedge clk);
    ins_valid = 0;
    chk(req, {31'b0, trap}, {31'b0, exp_t});
    chk(req, {31'b0, trap_local}, {31'b0, exp_l});
  endtask

  task automatic t_reset();
    chk("R1", {31'b0, mem_req}, 0);
    chk("R1", {31'b0, fault}, 0);
    chk("R1", {31'b0, trap}, 0);
    chk("R1", {31'b0, trap_local}, 0);
    chk("R1", {16'b0, fault_addr}, 0);
    @(negedge clk);
    access(16'hFFFF, 0, 18'h0FFFF, 1, "R1");
    fetch(6'h00, 1, 0, 0, "R1");
    fetch(6'h01, 1, 0, 0, "R1");
  endtask

  task automatic t_reloc();
    cfg(3'd0, 18'h00100, 1);
    access(16'h0010, 1, 18'h00110, 1, "R10");
    @(negedge clk);
    access(16'h1234, 0, 18'h01334, 1, "R2");
  endtask

  task automatic t_limit();
    cfg(3'd1, 18'h001FF, 1);
    access(16'h00FF, 0, 18'h001FF, 1, "R3");
    @(negedge clk);
    access(16'h0100, 1, 18'h0, 0, "R3");
    @(negedge clk);
    chk("R3", {31'b0, fault}, 0);
    chk("R4", {16'b0, fault_addr}, 16'h0100);
  endtask

  task automatic t_lock();
    cfg(3'd0, 18'h03000, 0);
    access(16'h0010, 0, 18'h00110, 1, "R6");
    cfg(3'd1, 18'h00000, 0);
    access(16'h00FF, 0, 18'h001FF, 1, "R6");
  endtask

  task automatic t_overflow();
    cfg(3'd1, 18'h3FFFF, 1);
    cfg(3'd0, 18'h3FF00, 1);
    access(16'h00FF, 0, 18'h3FFFF, 1, "R5");
    @(negedge clk);
    access(16'h0200, 0, 18'h0, 0, "R5");
  endtask

  task automatic t_trap();
    cfg(3'd2, 18'h30, 1);
    cfg(3'd3, 18'h3F, 1);
    cfg(3'd4, 18'h30, 1);
    cfg(3'd5, 18'h33, 1);
    fetch(6'h2F, 1, 0, 0, "R9");
    fetch(6'h30, 1, 1, 1, "R7");
    fetch(6'h33, 1, 1, 1, "R8");
    fetch(6'h34, 1, 1, 0, "R8");
    fetch(6'h3F, 1, 1, 0, "R7");
    fetch(6'h35, 0, 0, 0, "R9");
    cfg(3'd3, 18'h20, 0);
    fetch(6'h3F, 1, 1, 0, "R6");
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reloc();
    t_limit();
    t_lock();
    t_overflow();
    t_trap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule